// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block gives software a single-register way to fetch one 16-bit word from a three-wire serial EEPROM. Software writes the interface register with a request flag, a read flag and a word address. The block then drives the serial pins through a read frame: chip select high, a start bit, the read opcode, the address, and sixteen clocked-in data bits. When the frame ends, the block clears the request flag and places the word in the upper half of the same register.

A second, read-only control register shows whether an EEPROM is fitted. It reflects a strap input. When no EEPROM is fitted, a read request completes at once with a zero result, and the serial pins do not move.

The width of the address and the division from the system clock to the serial clock are parameters. With the defaults, a read takes about two hundred system cycles. That is far inside a software polling budget of many milliseconds.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, the interface register reads 0, and `ee_cs`, `ee_sk` and `ee_di` are low.
- R2: The control register (`bus_sel`=0) reads `ee_present` in bit 1 and 0 in every other bit. Writes to it change nothing.
- R3: A write to the interface register (`bus_sel`=1) starts a read when bit 7 (request) and bit 9 (read) are both set. From the next cycle, bit 7 reads 1 until the word is available, and then it reads 0.
- R4: The word address is taken from bits starting at bit 10, ADDR_BITS wide. While `ee_cs` is high, the block sends on `ee_di`, MSB first, the start bit 1, then the opcode bits 1 and 0, then the address. Each bit is valid at the rising edge of `ee_sk`.
- R5: After the address, the block takes sixteen data bits from `ee_do`, MSB first, sampling each one at the falling edge of `ee_sk`. The word appears in bits 31:16 of the interface register, bit 15 of the word in bit 31.
- R6: The block gives exactly 3+ADDR_BITS+16 `ee_sk` pulses per read. It lowers `ee_cs` after the last pulse. Bit 7 clears no later than (3+ADDR_BITS+16)*2*CLK_DIV+4 cycles after the request write.
- R7: With `ee_present` low, a read request never raises `ee_cs`. Bit 7 reads 0 from the cycle after the write, and bits 31:16 read 0.
- R8: A request write with bit 9 clear (for example bit 8, the write flag, instead) is ignored. No frame starts, bit 7 stays 0 and the stored result is kept.
- R9: Writes to the interface register while a read is in progress are ignored. The running frame and its address are unchanged.
- R10: `ee_sk` is high only while `ee_cs` is high, and each high phase lasts exactly CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 interface |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| ee_present | input | 1 | Strap: an EEPROM is fitted |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
The main read path is driven from a table of addresses at both ends of the address range and at alternating bit patterns. Each address is paired with an all-ones, all-zeros, alternating or edge-bit word. An address-bit swap then shows up in the captured command, and a bit-order or off-by-one error in the shift-in shows up in the returned word. Every read also checks the request-to-completion time against both ends of its window, the number of clock pulses and the width of the clock-high phase. Directed cases cover three more patterns: a second request during a busy read, a request with the write flag set instead of the read flag, and a request with no EEPROM fitted. These separate a guard that ignores such writes from one that restarts or corrupts the frame.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

   // Field positions in the interface register; software depends on these.
   localparam int unsigned REQ_BIT     = 7;
   localparam int unsigned WR_BIT      = 8;
   localparam int unsigned RD_BIT      = 9;
   localparam int unsigned ADDR_LSB    = 10;
   localparam int unsigned DATA_LSB    = 16;
   localparam int unsigned WORD_W      = 16;
   localparam int unsigned ADDR_FIELD  = DATA_LSB - ADDR_LSB;
   // Bit of the control register that shows an EEPROM is fitted.
   localparam int unsigned PRESENT_BIT = 1;
   // Start bit followed by the two read opcode bits.
   localparam logic [2:0]  RD_PREAMBLE = 3'b110;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_XMIT = 2'd1,
      SQ_RECV = 2'd2,
      SQ_STOP = 2'd3
   } sq_state_t;

endpackage

// File: rtl/eewr_clkdiv.sv
module eewr_clkdiv #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic half_tick
);

   generate
      if (DIV == 1) begin : g_nodiv
         assign half_tick = run;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(DIV - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign half_tick = run && (cnt_q == CW'(DIV - 1));

         // R10: the divider never counts past its terminal value
         a_r10_div_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/eewr_seq.sv
module eewr_seq
   import eewr_pkg::*;
#(
   parameter int unsigned ADDR_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [ADDR_BITS-1:0] addr,
   input  logic                 half_tick,
   input  logic                 ee_do,
   output logic                 ee_cs,
   output logic                 ee_sk,
   output logic                 ee_di,
   output logic                 active,
   output logic                 done,
   output logic [WORD_W-1:0]    word
);

   localparam int unsigned NOUT  = 3 + ADDR_BITS;
   localparam int unsigned CMAX  = (NOUT > WORD_W) ? NOUT : WORD_W;
   localparam int unsigned CNT_W = $clog2(CMAX);

   sq_state_t          state_q;
   logic               cs_q, sk_q, done_q;
   logic [NOUT-1:0]    out_sr_q;
   logic [WORD_W-1:0]  in_sr_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         cs_q     <= 1'b0;
         sk_q     <= 1'b0;
         done_q   <= 1'b0;
         out_sr_q <= '0;
         in_sr_q  <= '0;
         cnt_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  state_q  <= SQ_XMIT;
                  cs_q     <= 1'b1;
                  sk_q     <= 1'b0;
                  out_sr_q <= {RD_PREAMBLE, addr};
                  cnt_q    <= '0;
               end
            end
            SQ_XMIT: begin
               if (half_tick) begin
                  if (!sk_q) begin
                     sk_q <= 1'b1;
                  end else begin
                     sk_q     <= 1'b0;
                     out_sr_q <= out_sr_q << 1;
                     if (cnt_q == CNT_W'(NOUT - 1)) begin
                        cnt_q   <= '0;
                        state_q <= SQ_RECV;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
            end
            SQ_RECV: begin
               if (half_tick) begin
                  if (!sk_q) begin
                     sk_q <= 1'b1;
                  end else begin
                     sk_q    <= 1'b0;
                     in_sr_q <= {in_sr_q[WORD_W-2:0], ee_do};
                     if (cnt_q == CNT_W'(WORD_W - 1)) begin
                        state_q <= SQ_STOP;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
            end
            default: begin
               cs_q    <= 1'b0;
               state_q <= SQ_IDLE;
               done_q  <= 1'b1;
            end
         endcase
      end
   end

   assign ee_cs  = cs_q;
   assign ee_sk  = sk_q;
   assign ee_di  = (state_q == SQ_XMIT) && out_sr_q[NOUT-1];
   assign active = (state_q != SQ_IDLE);
   assign done   = done_q;
   assign word   = in_sr_q;

   // R10: the serial clock is high only inside a selected frame
   a_r10_sk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs);

   // R6: chip select is already low when completion is signalled
   a_r6_cs_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ee_cs);

   // R4: the first bit presented in a frame is the start bit
   a_r4_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> ee_di);

   // R4: data-in holds steady while the clock is high
   a_r4_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

endmodule

// File: rtl/eewr_regs.sv
module eewr_regs
   import eewr_pkg::*;
#(
   parameter int unsigned ADDR_BITS = 6,
   parameter int unsigned BOUND     = 204
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic                 present,
   input  logic                 seq_done,
   input  logic [WORD_W-1:0]    seq_word,
   output logic                 start,
   output logic [ADDR_BITS-1:0] rd_addr
);

   localparam int unsigned BC_W = $clog2(BOUND + 2);

   logic                 busy_q, rdflag_q, start_q;
   logic [ADDR_BITS-1:0] addr_q;
   logic [WORD_W-1:0]    result_q;
   logic                 wr_if, accept;
   logic [31:0]          if_word, ctl_word;

   assign wr_if  = bus_we && bus_sel;
   assign accept = wr_if && !busy_q && bus_wdata[REQ_BIT] && bus_wdata[RD_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         rdflag_q <= 1'b0;
         start_q  <= 1'b0;
         addr_q   <= '0;
         result_q <= '0;
      end else begin
         start_q <= 1'b0;
         if (accept) begin
            addr_q   <= bus_wdata[ADDR_LSB +: ADDR_BITS];
            rdflag_q <= 1'b1;
            if (present) begin
               busy_q  <= 1'b1;
               start_q <= 1'b1;
            end else begin
               result_q <= '0;
            end
         end else if (seq_done && busy_q) begin
            busy_q   <= 1'b0;
            result_q <= seq_word;
         end
      end
   end

   assign if_word  = {result_q, ADDR_FIELD'(addr_q), rdflag_q, 1'b0, busy_q, 7'b0};
   assign ctl_word = 32'(present) << PRESENT_BIT;
   assign bus_rdata = bus_sel ? if_word : ctl_word;
   assign start     = start_q;
   assign rd_addr   = addr_q;

   // Cycle counter for the completion window check.
   logic [BC_W-1:0] busy_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy_q) begin
         busy_cnt_q <= '0;
      end else if (busy_cnt_q != '1) begin
         busy_cnt_q <= busy_cnt_q + 1'b1;
      end
   end

   // R6: a started read finishes inside the fixed window
   a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt_q <= BC_W'(BOUND));

   // R9: the latched address holds for the whole read
   a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(addr_q));

   // R7: with no EEPROM fitted the request never goes busy
   a_r7_absent_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !present) |=> (!busy_q && result_q == '0));

   // R5: the result only moves on completion or an absent-device request
   a_r5_result_update: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_q) |-> ($past(seq_done) || $past(accept)));

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
   import eewr_pkg::*;
#(
   parameter int unsigned ADDR_BITS = 6,
   parameter int unsigned CLK_DIV   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ee_present,
   output logic        ee_cs,
   output logic        ee_sk,
   output logic        ee_di,
   input  logic        ee_do
);

   localparam int unsigned NPULSE = 3 + ADDR_BITS + WORD_W;
   localparam int unsigned BOUND  = NPULSE * 2 * CLK_DIV + 4;

   generate
      if (ADDR_BITS < 1 || ADDR_BITS > ADDR_FIELD) begin : g_bad_addr
         $error("ADDR_BITS must fit between bit 10 and bit 15");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
   endgenerate

   logic                 start, active, done, half_tick;
   logic [ADDR_BITS-1:0] rd_addr;
   logic [WORD_W-1:0]    word;

   eewr_regs #(.ADDR_BITS(ADDR_BITS), .BOUND(BOUND)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .present  (ee_present),
      .seq_done (done),
      .seq_word (word),
      .start    (start),
      .rd_addr  (rd_addr)
   );

   eewr_clkdiv #(.DIV(CLK_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (active),
      .half_tick(half_tick)
   );

   eewr_seq #(.ADDR_BITS(ADDR_BITS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .addr     (rd_addr),
      .half_tick(half_tick),
      .ee_do    (ee_do),
      .ee_cs    (ee_cs),
      .ee_sk    (ee_sk),
      .ee_di    (ee_di),
      .active   (active),
      .done     (done),
      .word     (word)
   );

endmodule

// File: tb/eeprom_word_reader_tb.sv
module eeprom_word_reader_tb;

   localparam int unsigned A      = 6;
   localparam int unsigned DIV    = 4;
   localparam int unsigned NOUT   = 3 + A;
   localparam int unsigned NPULSE = NOUT + 16;
   localparam int unsigned BOUND  = NPULSE * 2 * DIV + 4;
   localparam int unsigned MINCYC = NPULSE * 2 * DIV;

   // {address, word stored there}
   localparam logic [21:0] VEC [6] = '{
      {6'd0,  16'h8001}, {6'd63, 16'h7FFE}, {6'd21, 16'hA5A5},
      {6'd42, 16'h5A5A}, {6'd1,  16'hFFFF}, {6'd32, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, ee_present = 1'b1;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        ee_cs, ee_sk, ee_di;
   logic        ee_do = 1'b0;

   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   eeprom_word_reader #(.ADDR_BITS(A), .CLK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ee_present(ee_present),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   // EEPROM responder
   logic [15:0]     mem [64];
   logic [NOUT-1:0] cmd = '0;
   int              rcnt = 0, last_pulses = 0, cs_rises = 0;
   int              hi_run = 0, last_hi = 0;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = {i[5:0], ~i[5:0], 4'h3};
      for (int i = 0; i < 6; i++) mem[VEC[i][21:16]] = VEC[i][15:0];
   end

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         last_pulses <= rcnt;
         rcnt        <= 0;
         ee_do       <= 1'b0;
      end else begin
         if (rcnt < NOUT) cmd <= {cmd[NOUT-2:0], ee_di};
         else if (rcnt < NPULSE) ee_do <= mem[cmd[A-1:0]][15 - (rcnt - NOUT)];
         rcnt <= rcnt + 1;
      end
   end

   always @(posedge ee_cs) cs_rises <= cs_rises + 1;

   always @(posedge clk) begin
      if (ee_sk) hi_run <= hi_run + 1;
      else if (hi_run != 0) begin
         last_hi <= hi_run;
         hi_run  <= 0;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_sel = 1'b1;
   endtask

   task automatic bus_read(input logic sel, output logic [31:0] d);
      bus_sel = sel;
      #1 d = bus_rdata;
      bus_sel = 1'b1;
   endtask

   task automatic wait_done(output int cyc);
      logic [31:0] v;
      cyc = 1;
      bus_read(1'b1, v);
      while (v[7] && cyc < 1000) begin
         @(negedge clk);
         cyc++;
         bus_read(1'b1, v);
      end
   endtask

   function automatic logic [31:0] rd_req(input logic [5:0] a);
      return (32'(a) << 10) | 32'h280;
   endfunction

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] keep;
      int cyc, rises;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(1'b1, v);
      check(v == 32'h0, "R1 interface reg", v, 32'h0);
      check({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins idle", 32'({ee_cs, ee_sk, ee_di}), 32'h0);

      // R2 control register
      bus_read(1'b0, v);
      check(v == 32'h2, "R2 present bit", v, 32'h2);
      bus_write(1'b0, 32'hFFFF_FFFF);
      bus_read(1'b0, v);
      check(v == 32'h2, "R2 write ignored", v, 32'h2);

      // table-driven reads: R3 R4 R5 R6 R10
      for (int i = 0; i < 6; i++) begin
         bus_write(1'b1, rd_req(VEC[i][21:16]));
         bus_read(1'b1, v);
         check(v[7] == 1'b1, "R3 busy set", 32'(v[7]), 32'h1);
         wait_done(cyc);
         check(cyc <= BOUND && cyc >= MINCYC, "R6 completion window", 32'(cyc), 32'(BOUND));
         bus_read(1'b1, v);
         check(v[7] == 1'b0, "R3 busy cleared", 32'(v[7]), 32'h0);
         check(v[31:16] == VEC[i][15:0], "R5 word", 32'(v[31:16]), 32'(VEC[i][15:0]));
         check(v[15:10] == VEC[i][21:16], "R4 address readback", 32'(v[15:10]), 32'(VEC[i][21:16]));
         check(cmd == {3'b110, VEC[i][21:16]}, "R4 serial command", 32'(cmd), 32'({3'b110, VEC[i][21:16]}));
         check(last_pulses == NPULSE && !ee_cs, "R6 pulse count", 32'(last_pulses), 32'(NPULSE));
         check(last_hi == DIV, "R10 clock high width", 32'(last_hi), 32'(DIV));
      end

      // R9 writes during a busy read are ignored
      bus_write(1'b1, rd_req(6'd5));
      repeat (20) @(negedge clk);
      bus_write(1'b1, rd_req(6'd9));
      wait_done(cyc);
      bus_read(1'b1, v);
      check(v[31:16] == 16'h17A3, "R9 word from first address", 32'(v[31:16]), 32'h17A3);
      check(cmd == {3'b110, 6'd5}, "R9 frame address", 32'(cmd), 32'({3'b110, 6'd5}));
      check(v[15:10] == 6'd5, "R9 address kept", 32'(v[15:10]), 32'd5);

      // R8 request without read flag
      keep  = v;
      rises = cs_rises;
      bus_write(1'b1, (32'd3 << 10) | 32'h180);
      bus_read(1'b1, v);
      check(v == keep, "R8 write-op ignored", v, keep);
      bus_write(1'b1, 32'h80);
      repeat (10) @(negedge clk);
      bus_read(1'b1, v);
      check(v == keep && cs_rises == rises, "R8 bare request ignored", v, keep);

      // R7 no EEPROM fitted
      ee_present = 1'b0;
      #1;
      bus_read(1'b0, v);
      check(v == 32'h0, "R2 absent control", v, 32'h0);
      bus_write(1'b1, rd_req(6'd21));
      bus_read(1'b1, v);
      check(v[7] == 1'b0, "R7 no busy", 32'(v[7]), 32'h0);
      check(v[31:16] == 16'h0, "R7 zero result", 32'(v[31:16]), 32'h0);
      repeat (10) @(negedge clk);
      check(cs_rises == rises, "R7 no chip select", 32'(cs_rises), 32'(rises));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule